// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects up to `NUM_SRC` interrupt sources into one group of word registers. A one-cycle pulse on an event input latches the matching cause bit. A mask register blocks individual sources. A masked-cause view shows only the sources that are not blocked. The block drives a single interrupt line, which is high while any unmasked cause bit is pending. Bit n of every register belongs to source n.

Each source has its own clear mode. In one mode, software clears a cause bit by writing a one to it. In the other mode, reading the cause bit clears it. Software can raise any cause bit itself through a write-only set register. The mask can be written directly. It can also be updated through set-only and clear-only aliases, so no read-modify-write is needed.

The register port accepts one request per cycle and never applies back-pressure, so it has no ready signal. A read returns its data with `rsp_valid` exactly one cycle after the request. Writes produce no response.

Top module: `irq_cause_mask_bank`

## Requirements
- R1: After reset, every cause bit is 0, every mask bit is 1, every clear-mode bit is 0, `irq_o` is 0 and `rsp_valid` is 0.
- R2: An event pulse on `evt_i[n]` sets cause bit n on the next clock edge. The cause register, at byte offset 0x04, reads back the latched bits. No cause bit rises without an event or a software set.
- R3: The clear-mode register is at 0x00. When clear-mode bit n is 0, writing 1 to bit n at 0x04 or 0x08 clears cause bit n. Zero bits in the write data have no effect. Reading these offsets does not clear the bit.
- R4: When clear-mode bit n is 1, reading 0x04 or 0x08 returns cause bit n and then clears it. Writes to those offsets leave the bit unchanged. The clear-mode register can be read and written.
- R5: If an event for bit n arrives in the same cycle as a clear of bit n, by read or by write, cause bit n stays set.
- R6: Writing 1 to bit n of the cause-set register at 0x0C sets cause bit n. Zero bits have no effect. This register reads as zero.
- R7: The mask register at 0x10 can be read and written directly. Writing 1s to the mask-set alias at 0x14 sets those mask bits. Writing 1s to the mask-clear alias at 0x18 clears those mask bits. Zero bits in either alias have no effect, and both aliases read as zero.
- R8: The masked-cause register at 0x08 reads as cause AND NOT mask.
- R9: `irq_o` equals the OR of all masked-cause bits, delayed by one register stage.
- R10: A read request gives `rsp_valid` = 1 on the next cycle, with the register value as it was before that access took effect. A write request gives `rsp_valid` = 0. Requests are accepted every cycle.
- R11: Offset 0x1C and every offset above it are reserved. They read as zero, and writes to them change no register. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | NUM_SRC | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_data | output | NUM_SRC | Read data |
| evt_i | input | NUM_SRC | Hardware event pulses, one per source |
| irq_o | output | 1 | Registered OR of the masked cause bits |

## Verification
The hardest case to reach is an event that arrives in exactly the cycle a cause bit is being cleared. There are two forms: a write-one-to-clear write, and a clear-on-read read. The bench drives `evt_i` together with the access request on the same edge, in both clear modes, and then reads the cause back to confirm the bit survived. It also sweeps every 8-bit value through the cause-set, mask and masked-cause registers of an 8-source instance. For every access it compares the read data and the interrupt line against a bench model.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  typedef enum logic [2:0] {
    SEL_MODE     = 3'd0,
    SEL_CAUSE    = 3'd1,
    SEL_MASKED   = 3'd2,
    SEL_SET      = 3'd3,
    SEL_MASK     = 3'd4,
    SEL_MASK_SET = 3'd5,
    SEL_MASK_CLR = 3'd6,
    SEL_RSVD     = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic wr_mode;
    logic wr_cause;
    logic rd_cause;
    logic wr_set;
    logic wr_mask;
    logic wr_mask_set;
    logic wr_mask_clr;
  } bank_strobe_t;

endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output reg_sel_e          sel_o,
  output bank_strobe_t      stb_o
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = 4;

  logic       hi_nz;
  logic [1:0] unused_lo;
  assign unused_lo = req_addr_i[1:0];

  generate
    if (ADDR_W > IDX_HI + 1) begin : g_hi
      assign hi_nz = |req_addr_i[ADDR_W-1:IDX_HI+1];
    end else begin : g_nohi
      assign hi_nz = 1'b0;
    end
  endgenerate

  always_comb begin
    sel_o = hi_nz ? SEL_RSVD : reg_sel_e'(req_addr_i[IDX_HI:IDX_LO]);
    stb_o = '0;
    if (req_valid_i) begin
      if (req_write_i) begin
        unique case (sel_o)
          SEL_MODE:               stb_o.wr_mode     = 1'b1;
          SEL_CAUSE, SEL_MASKED:  stb_o.wr_cause    = 1'b1;
          SEL_SET:                stb_o.wr_set      = 1'b1;
          SEL_MASK:               stb_o.wr_mask     = 1'b1;
          SEL_MASK_SET:           stb_o.wr_mask_set = 1'b1;
          SEL_MASK_CLR:           stb_o.wr_mask_clr = 1'b1;
          default: ;
        endcase
      end else if (sel_o == SEL_CAUSE || sel_o == SEL_MASKED) begin
        stb_o.rd_cause = 1'b1;
      end
    end
  end

  always_comb begin
    assert ($countones({stb_o.wr_mode, stb_o.wr_cause, stb_o.rd_cause, stb_o.wr_set,
                        stb_o.wr_mask, stb_o.wr_mask_set, stb_o.wr_mask_clr}) <= 1)
      else $error("AST_ONE_STROBE");  // R10
  end

endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] sw_set_i,
  input  logic               wr_clr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic               rd_clr_i,
  input  logic [NUM_SRC-1:0] mode_i,
  output logic [NUM_SRC-1:0] cause_o
);
  logic [NUM_SRC-1:0] cause_q;

  generate
    for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
      logic clr_b;
      assign clr_b = (wr_clr_i & wdata_i[b] & ~mode_i[b]) | (rd_clr_i & mode_i[b]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_q[b] <= 1'b0;
        else        cause_q[b] <= (cause_q[b] & ~clr_b) | evt_i[b] | sw_set_i[b];
      end
    end
  endgenerate

  assign cause_o = cause_q;

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));  // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(evt_i | sw_set_i)) == '0));  // R2
  AST_READ_KEEPS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_i |=> (($past(cause_q & ~mode_i) & ~cause_q) == '0));  // R3
  AST_COR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && !(|evt_i) && !(|sw_set_i)) |=> ((cause_q & $past(mode_i)) == '0));  // R4

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic               wr_set_i,
  input  logic               wr_clr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '1;
    else if (wr_i)     mask_q <= wdata_i;
    else if (wr_set_i) mask_q <= mask_q | wdata_i;
    else if (wr_clr_i) mask_q <= mask_q & ~wdata_i;
  end

  assign mask_o = mask_q;

  AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));  // R7
  AST_MASK_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_i |=> ((mask_q & $past(wdata_i)) == '0));  // R7
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i || wr_set_i || wr_clr_i) |=> $stable(mask_q));  // R7

endmodule

// File: rtl/irq_cause_mask_bank.sv
module irq_cause_mask_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [NUM_SRC-1:0] req_wdata,
  output logic               rsp_valid,
  output logic [NUM_SRC-1:0] rsp_data,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic               irq_o
);
  reg_sel_e           sel;
  bank_strobe_t       stb;
  logic [NUM_SRC-1:0] mode_q;
  logic [NUM_SRC-1:0] cause;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] sw_set;
  logic [NUM_SRC-1:0] rd_mux;
  logic               rsp_valid_q;
  logic [NUM_SRC-1:0] rsp_data_q;
  logic               irq_q;

  irq_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid_i (req_valid),
    .req_write_i (req_write),
    .req_addr_i  (req_addr),
    .sel_o       (sel),
    .stb_o       (stb)
  );

  assign sw_set = stb.wr_set ? req_wdata : '0;

  irq_cause_reg #(.NUM_SRC(NUM_SRC)) u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .sw_set_i (sw_set),
    .wr_clr_i (stb.wr_cause),
    .wdata_i  (req_wdata),
    .rd_clr_i (stb.rd_cause),
    .mode_i   (mode_q),
    .cause_o  (cause)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (stb.wr_mask),
    .wr_set_i (stb.wr_mask_set),
    .wr_clr_i (stb.wr_mask_clr),
    .wdata_i  (req_wdata),
    .mask_o   (mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode_q <= '0;
    else if (stb.wr_mode) mode_q <= req_wdata;
  end

  always_comb begin
    unique case (sel)
      SEL_MODE:   rd_mux = mode_q;
      SEL_CAUSE:  rd_mux = cause;
      SEL_MASKED: rd_mux = cause & ~mask;
      SEL_MASK:   rd_mux = mask;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      irq_q       <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid & ~req_write;
      rsp_data_q  <= (req_valid & ~req_write) ? rd_mux : '0;
      irq_q       <= |(cause & ~mask);
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign irq_o     = irq_q;

  AST_RSVD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && sel == SEL_RSVD) |=> ($stable(mask) && $stable(mode_q)));  // R11
  AST_IRQ_QUIET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&$past(mask)) |-> !irq_o);  // R9
  AST_WRITE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_valid);  // R10

endmodule

// File: tb/irq_cause_mask_bank_tb_top.sv
module irq_cause_mask_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [N-1:0]  req_wdata, evt;
  logic          rsp_valid, irq;
  logic [N-1:0]  rsp_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [N-1:0] m_cause, m_mask, m_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cause_mask_bank #(.NUM_SRC(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .evt_i(evt), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one access (or idle when v=0); called at a falling edge
  task automatic acc(input bit v, input bit w, input int idx, input logic [N-1:0] wd,
                     input logic [N-1:0] ev, input string tag);
    logic [N-1:0] e_rsp, clr, set;
    bit e_rv, e_irq;
    e_irq = |(m_cause & ~m_mask);
    e_rv  = v && !w;
    case (idx)
      0: e_rsp = m_mode;
      1: e_rsp = m_cause;
      2: e_rsp = m_cause & ~m_mask;
      4: e_rsp = m_mask;
      default: e_rsp = '0;
    endcase
    clr = '0; set = '0;
    if (v && w) begin
      case (idx)
        0: m_mode = wd;
        1, 2: clr = wd & ~m_mode;
        3: set = wd;
        4: m_mask = wd;
        5: m_mask = m_mask | wd;
        6: m_mask = m_mask & ~wd;
        default: ;
      endcase
    end else if (v && (idx == 1 || idx == 2)) begin
      clr = m_mode;
    end
    m_cause = (m_cause & ~clr) | ev | set;
    req_valid = v; req_write = w; req_addr = AW'(idx * 4); req_wdata = wd; evt = ev;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; evt = '0;
    check("R10 rsp_valid", rsp_valid, e_rv);
    if (e_rv) check(tag, rsp_data, e_rsp);
    check("R9 irq", irq, e_irq);
  endtask

  task automatic rd(input int idx, input string tag);
    acc(1'b1, 1'b0, idx, '0, '0, tag);
  endtask

  task automatic wr(input int idx, input logic [N-1:0] wd, input string tag);
    acc(1'b1, 1'b1, idx, wd, '0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; evt = '0;
    m_cause = '0; m_mask = '1; m_mode = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    for (int i = 0; i < 8; i++) rd(i, "R1 reset readback");

    // R2 each event bit, then W1C clear (R3)
    for (int i = 0; i < N; i++) begin
      acc(1'b0, 1'b0, 0, '0, N'(1 << i), "R2 evt");
      rd(1, "R2 cause");
      rd(1, "R3 read keeps w1c");
      wr(1, N'(1 << i), "R3 w1c");
      rd(1, "R3 after clear");
    end

    // R6 / R8 / R7 exhaustive value sweep
    for (int v = 0; v < 256; v++) begin
      wr(3, N'(v), "R6 set");
      rd(3, "R6 set reads zero");
      wr(4, N'(v) ^ 8'h5A, "R7 mask write");
      rd(4, "R7 mask read");
      rd(2, "R8 masked");
      wr(2, 8'hFF, "R3 clear via masked");
      rd(1, "R3 cleared");
    end

    // R7 aliases
    wr(4, 8'h00, "R7 mask zero");
    for (int p = 0; p < 16; p++) begin
      wr(5, N'(p * 17) ^ 8'h81, "R7 mask set");
      rd(4, "R7 after set");
      wr(6, N'(p * 5), "R7 mask clr");
      rd(4, "R7 after clr");
      rd(5, "R7 set alias reads zero");
      rd(6, "R7 clr alias reads zero");
    end

    // R4 clear-on-read with mixed modes
    wr(4, 8'h0F, "R7 mask");
    for (int k = 0; k < 4; k++) begin
      logic [N-1:0] md;
      md = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hA5 : 8'h3C;
      wr(0, md, "R4 mode write");
      rd(0, "R4 mode read");
      acc(1'b0, 1'b0, 0, '0, 8'hFF, "R2 evt all");
      rd(1, "R4 cor read");
      rd(1, "R4 after cor");
      wr(1, 8'hFF, "R4 write ignored on cor");
      rd(2, "R4 masked cor read");
      rd(1, "R4 after masked read");
      acc(1'b0, 1'b0, 0, '0, 8'hFF, "R2 evt all");
      wr(2, 8'hFF, "R3 w1c via masked");
      rd(1, "R3 residual");
      wr(0, 8'hFF, "R4 mode all cor");
      rd(1, "R4 drain");
    end

    // R5 event coinciding with clear
    wr(0, 8'h00, "R5 mode w1c");
    wr(4, 8'h00, "R7 unmask");
    acc(1'b0, 1'b0, 0, '0, 8'h01, "R2 evt");
    acc(1'b1, 1'b1, 1, 8'h01, 8'h01, "R5 w1c collide");
    rd(1, "R5 bit kept after w1c");
    wr(1, 8'hFF, "R3 clear");
    wr(0, 8'hFF, "R5 mode cor");
    acc(1'b0, 1'b0, 0, '0, 8'h02, "R2 evt");
    acc(1'b1, 1'b0, 1, '0, 8'h02, "R5 cor collide");
    rd(1, "R5 bit kept after cor");
    rd(1, "R5 cleared later");

    // R11 reserved offset
    wr(0, 8'h00, "R11 mode");
    wr(4, 8'h33, "R11 mask");
    wr(7, 8'hFF, "R11 rsvd write");
    rd(7, "R11 rsvd read");
    rd(0, "R11 mode unchanged");
    rd(4, "R11 mask unchanged");
    rd(1, "R11 cause unchanged");
    acc(1'b0, 1'b0, 0, '0, '0, "R9 idle");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule